// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of a single read or write burst inside a row that is already open. A start strobe captures a start column, a burst length code and an ordering choice. From the next clock on, the block issues one column address per cycle until the burst runs out or a stop request ends it, and it flags the final beat. The controller around it feeds those addresses to the memory command path.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. They walk that block either in counting order with wraparound or in exclusive-or order. A full-row burst steps through every column of the row in counting order, wrapping at the row end, and keeps going until it is stopped.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `col_valid` and `col_last` are 0.
- R2: When `start` is 1 at a clock edge, the next cycle has `col_valid`=1 and `col_addr` equal to the sampled `start_col`.
- R3: `blen_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any value from 4 to 7 selects a full-row burst.
- R4: In counting order with length N, beat k has its low log2(N) bits equal to (start + k) mod N, and its upper bits equal to those of the start column.
- R5: With `interleave`=1 and length N, beat k equals the start column with its low log2(N) bits exclusive-ored with k.
- R6: A full-row burst always counts up by one column per beat, whatever `interleave` is. It wraps from the top column to column 0 and continues until it is stopped.
- R7: On the final beat of a fixed-length burst, `col_last` is 1. In the next cycle `col_valid` is 0, unless a new start was taken.
- R8: When `stop` is 1 while `col_valid` is 1, that beat has `col_last`=1 and the burst ends at the clock edge. When `stop` is 1 while the block is idle, it has no effect.
- R9: A `start` during a burst abandons the current burst. The new burst's first beat appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst using the inputs sampled at this edge |
| start_col | input | COL_W | First column of the burst |
| blen_code | input | 3 | Length code: 0..3 give 1,2,4,8 beats; 4..7 give a full row |
| interleave | input | 1 | 1 selects exclusive-or ordering for fixed lengths |
| stop | input | 1 | End the current burst on this beat |
| col_valid | output | 1 | A column address is issued this cycle |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | The current beat is the final one |

## Verification
The bench builds the block with its default COL_W of 8, which gives a 256-column row. With that width, the wrap from column 255 to 0 is reached in a few beats by starting a full-row burst near the top of the row. Starting columns with nonzero low bits exercise wraparound inside a block in both orderings. Stops, restarts and idle stops are driven at chosen beats, and a behavioural model predicts every cycle.

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_code,
  input  logic             interleave,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             busy_q;
  logic             ilv_q;
  logic             full_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] mask_d;
  logic [COL_W-1:0] low_lin;
  logic [COL_W-1:0] low_ilv;
  logic             final_beat;

  assign mask_d = blen_code[2] ? ALL_ONES : COL_W'((4'd1 << blen_code[1:0]) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ilv_q  <= interleave & ~blen_code[2];
      full_q <= blen_code[2];
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (busy_q) begin
      if (stop || final_beat) busy_q <= 1'b0;
      else beat_q <= beat_q + 1'b1;
    end
  end

  assign low_lin    = (base_q + beat_q) & mask_q;
  assign low_ilv    = (base_q ^ beat_q) & mask_q;
  assign final_beat = busy_q & ~full_q & (beat_q == mask_q);

  assign col_valid = busy_q;
  assign col_addr  = (base_q & ~mask_q) | (ilv_q ? low_ilv : low_lin);
  assign col_last  = busy_q & (stop | final_beat);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_addr == $past(start_col)); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && !start |=> !col_valid); // R7

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && full_q && !col_last && !start |=> col_valid && col_addr == COL_W'($past(col_addr) + 1'b1)); // R6

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !start |=> (col_addr & ~mask_q) == ($past(col_addr) & ~$past(mask_q))); // R4

  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid && !start |=> !col_valid); // R8

endmodule

// File: tb/tb_sdram_burst_colseq.sv
`timescale 1ns/100ps
module tb_sdram_burst_colseq;
  localparam int COL_W = 8;
  localparam int ROW = 1 << COL_W;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] blen_code = '0;
  logic interleave = 0;
  logic stop = 0;
  logic col_valid, col_last;
  logic [COL_W-1:0] col_addr;

  sdram_burst_colseq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .blen_code(blen_code), .interleave(interleave), .stop(stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_act = 0;
  int m_base = 0, m_k = 0, m_n = 1, m_full = 0, m_ilv = 0;

  function automatic int exp_addr();
    if (m_full) return (m_base + m_k) % ROW;
    if (m_ilv) return (m_base & ~(m_n - 1)) | ((m_base ^ m_k) & (m_n - 1));
    return (m_base & ~(m_n - 1)) | ((m_base + m_k) % m_n);
  endfunction

  task automatic compare();
    bit ev, el;
    int ea;
    ev = m_act;
    el = m_act && (stop || (!m_full && m_k == m_n - 1));
    ea = exp_addr();
    total++;
    if (col_valid !== ev || col_last !== el || (ev && int'(col_addr) != ea)) begin
      bad++;
      $display("FAIL %s: valid=%0b last=%0b addr=%0h expected valid=%0b last=%0b addr=%0h",
               tag, col_valid, col_last, col_addr, ev, el, ev ? ea : 0);
    end
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    if (!rst_n) m_act = 0;
    else if (start) begin
      m_act = 1; m_base = start_col; m_k = 0;
      m_full = blen_code >= 4;
      m_n = m_full ? ROW : (1 << blen_code);
      m_ilv = interleave && !m_full;
    end else if (m_act) begin
      if (stop || (!m_full && m_k == m_n - 1)) m_act = 0;
      else m_k++;
    end
    @(negedge clk);
  endtask

  task automatic launch(input int col, input int code, input bit ilv);
    start = 1; start_col = COL_W'(col); blen_code = 3'(code); interleave = ilv;
    tick();
    start = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R1"; idle(3);
    rst_n = 1; idle(2);
    tag = "R2_R4"; launch(8'h35, 2, 0); idle(5);
    tag = "R5"; launch(8'h5B, 3, 1); idle(9);
    tag = "R3_len1"; launch(8'h77, 0, 0); idle(2);
    tag = "R3_len2"; launch(8'h11, 1, 1); idle(3);
    tag = "R4_len8"; launch(8'hC6, 3, 0); idle(9);
    tag = "R6"; launch(8'hFD, 5, 1); idle(5);
    stop = 1; tag = "R8_stop_full"; tick(); stop = 0;
    tag = "R8_idle"; idle(1); stop = 1; idle(2); stop = 0; idle(1);
    tag = "R8_stop_fixed"; launch(8'h40, 3, 0); idle(2); stop = 1; tick(); stop = 0; idle(2);
    tag = "R9"; launch(8'h23, 3, 1); idle(2);
    launch(8'hA2, 2, 0); idle(6);
    tag = "R9_R7"; launch(8'h80, 1, 0); tick(); launch(8'h0F, 7, 0); idle(3);
    stop = 1; tick(); stop = 0; idle(2);
    tag = "R6_long"; launch(8'h00, 4, 0); idle(ROW + 3); stop = 1; tick(); stop = 0; idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule